// File: doc/BRIEF.md
# Synchronizable PWM Gate Generator

This block drives the gate of a boost power switch from a digital sawtooth and a digital duty word. The duty word takes the place of the analog current-loop output. When no usable external timing train is present, the sawtooth free-runs with a period set by a programmable word. When a qualified external SYNC train is present, the block locks to it. Each gate period then spans exactly two SYNC periods, so the gate runs at half the SYNC rate.

The gate rises only at the start of a sawtooth cycle. It falls when the sawtooth reaches the duty word, when the guaranteed off-time begins, or on the edge after a peak-current flag is seen outside the leading-edge blanking window, whichever comes first.

SYNC is qualified in three ways: by the width of each pulse, by the spacing between qualified pulses, and by a timeout. A train that fails any of these hands the period back to the internal counter. An enable input clears the gate and the lock at the next clock edge. The block has no streaming interface. All of its pins are plain control and status levels.

Top module: `pwm_sync_gate`

## Requirements
- R1: During reset and on the first cycles after it, the gate output is low.
- R2: Unlocked and enabled, the sawtooth counts from 0 to `period` and wraps. The gate period is `period+1` clocks, and the gate rises only in the cycle in which the sawtooth is 0.
- R3: Without a current-limit event, the gate stays high for exactly `duty` clocks, as long as `duty` is below the duty ceiling. A `duty` of 0 produces no pulse at all.
- R4: The duty ceiling is `period+1-MIN_OFF` clocks when unlocked and `2*I-MIN_OFF` clocks when locked, where I is the captured SYNC spacing. This guarantees an off-time of at least `MIN_OFF` clocks in every cycle.
- R5: When `ocp` is high at a clock edge where the sawtooth is at or above `BLANK_CYC`, the gate is low after that edge and stays low until the next cycle start. With `ocp` held high, each pulse is `BLANK_CYC+1` clocks long.
- R6: `ocp` is ignored while the sawtooth is below `BLANK_CYC`, so a flag present only in that window leaves the pulse width unchanged.
- R7: SYNC passes through two flops. A pulse qualifies only if its synchronized high time is between `SYNC_WMIN` and `SYNC_WMAX` clocks. Any other pulse is ignored and does not change the lock state.
- R8: A qualified falling edge locks the block when it comes a spacing I after the previous qualified falling edge, with `I >= SYNC_IMIN` and `2*I <= period+1+SYNC_MARGIN`. Once locked, the sawtooth restarts on every second valid edge, so the gate period is `2*I`.
- R9: A qualified pulse whose spacing breaks the limits in R8 releases the lock, and the sawtooth resumes free-running at `period+1`.
- R10: When locked, if no qualified pulse arrives for more than `period+SYNC_MARGIN` clocks, the lock is released and the block free-runs.
- R11: A low `en` at a clock edge forces the gate low after that edge and clears the lock. After `en` returns, the block free-runs from a fresh cycle start, and the divide-by-two phase restarts with the next valid SYNC edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; low forces the gate low and drops the lock |
| duty | input | CW | Duty command in clocks, compared with the sawtooth |
| period | input | CW | Free-running sawtooth terminal count (gate period minus one) |
| sync_in | input | 1 | External SYNC level, asynchronous |
| ocp | input | 1 | Peak-current comparator flag, synchronous to clk |
| gate | output | 1 | Gate drive for the power switch |

## Verification
The assertions rely on a few conditions at the inputs. `ocp`, `duty` and `period` must be synchronous to `clk`, and `period` must be no smaller than `MIN_OFF`, so that the duty ceiling is never negative. Only `sync_in` may arrive asynchronously.

The stimulus drives every input on the falling clock edge. It changes `period` only while the block is disabled or idle. Its SYNC trains are built from whole clock cycles, so the synchronized pulse widths and spacings are known exactly. Each train is either clearly inside the R7 and R8 limits or clearly outside them.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;
  // Which timebase owns the sawtooth.
  typedef enum logic {
    RUN_FREE   = 1'b0,
    RUN_LOCKED = 1'b1
  } run_mode_e;
endpackage

// File: rtl/pwm_sync_qual.sv
module pwm_sync_qual
  import pwm_gate_pkg::*;
#(
  parameter int CW          = 12,
  parameter int SYNC_WMIN   = 25,
  parameter int SYNC_WMAX   = 3950,
  parameter int SYNC_IMIN   = 1000,
  parameter int SYNC_MARGIN = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          sync_in,
  input  logic [CW-1:0] period,
  output logic          locked,
  output logic          restart,
  output logic [CW:0]   ival
);
  localparam int WW = $clog2(SYNC_WMAX + 2);
  localparam int IW = CW + 2;
  localparam logic [WW-1:0] WMIN_V = WW'(SYNC_WMIN);
  localparam logic [WW-1:0] WMAX_V = WW'(SYNC_WMAX);

  logic s_meta, s_sync, s_prev;
  logic [WW-1:0] wcnt;
  logic [IW-1:0] icnt;
  logic          have_prev;
  logic          phase;
  run_mode_e     mode, mode_nx;

  logic rise, fall, width_ok, frame_ok, edge_ok, timeout, ph_eff;

  assign rise     = s_sync & ~s_prev;
  assign fall     = ~s_sync & s_prev;
  assign width_ok = fall && (wcnt >= WMIN_V) && (wcnt <= WMAX_V);
  assign frame_ok = have_prev && (icnt >= IW'(SYNC_IMIN)) &&
                    ({icnt, 1'b0} <= ((IW+1)'(period) + (IW+1)'(1 + SYNC_MARGIN)));
  assign edge_ok  = width_ok && frame_ok;
  assign timeout  = (mode == RUN_LOCKED) && (icnt > (IW'(period) + IW'(SYNC_MARGIN)));
  assign ph_eff   = (mode == RUN_LOCKED) && phase;
  assign restart  = en && edge_ok && !ph_eff;
  assign locked   = (mode == RUN_LOCKED);

  always_comb begin
    if (!en)                      mode_nx = RUN_FREE;
    else if (edge_ok)             mode_nx = RUN_LOCKED;
    else if (width_ok || timeout) mode_nx = RUN_FREE;
    else                          mode_nx = mode;
  end

  // Two-flop synchronizer plus one history flop for edge detection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_meta <= 1'b0;
      s_sync <= 1'b0;
      s_prev <= 1'b0;
    end else begin
      s_meta <= sync_in;
      s_sync <= s_meta;
      s_prev <= s_sync;
    end
  end

  // High-time measurement, saturating one above the upper limit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        wcnt <= '0;
    else if (rise)                     wcnt <= WW'(1);
    else if (s_sync && wcnt <= WMAX_V) wcnt <= wcnt + 1'b1;
  end

  // Spacing between width-qualified falling edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt      <= '0;
      have_prev <= 1'b0;
    end else begin
      if (width_ok)   icnt <= IW'(1);
      else if (~&icnt) icnt <= icnt + 1'b1;
      if (width_ok)   have_prev <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= RUN_FREE;
      phase <= 1'b0;
      ival  <= '0;
    end else begin
      mode <= mode_nx;
      if (mode_nx == RUN_FREE) phase <= 1'b0;
      else if (edge_ok)        phase <= ~ph_eff;
      if (edge_ok)             ival <= icnt[CW:0];
    end
  end

  // R8: a valid SYNC edge while enabled leaves the block locked.
  a_r8_lock_on_valid_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (en && width_ok && frame_ok) |=> locked);

  // R10: overdue SYNC hands the period back to the internal counter.
  a_r10_timeout_release: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && icnt > (IW'(period) + IW'(SYNC_MARGIN))) |=> !locked);

  // R7: a pulse of illegal width does not touch the captured spacing.
  a_r7_bad_width_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && (wcnt < WMIN_V || wcnt > WMAX_V)) |=> $stable(ival));

  // R11: disabling always drops the lock.
  a_r11_disable_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !locked);
endmodule

// File: rtl/pwm_ramp.sv
module pwm_ramp #(
  parameter int CW      = 12,
  parameter int MIN_OFF = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] period,
  input  logic          locked,
  input  logic          restart,
  input  logic [CW:0]   ival,
  output logic [CW:0]   cnt,
  output logic [CW:0]   cnt_nx,
  output logic [CW+1:0] lim
);
  localparam int CNW = CW + 1;
  localparam int LW  = CW + 2;

  // Duty ceiling: cycle length minus the guaranteed off-time.
  assign lim = locked ? ({ival, 1'b0} - LW'(MIN_OFF))
                      : (LW'(period) + LW'(1) - LW'(MIN_OFF));

  always_comb begin
    if (!en)                        cnt_nx = '1;
    else if (restart)               cnt_nx = '0;
    else if (locked)                cnt_nx = (&cnt) ? cnt : cnt + 1'b1;
    else if (cnt >= CNW'(period))   cnt_nx = '0;
    else                            cnt_nx = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '1;
    else        cnt <= cnt_nx;
  end

  // R2: the free-running sawtooth wraps after reaching the period word.
  a_r2_free_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !locked && !restart && cnt >= CNW'(period)) |=> (cnt == '0));
endmodule

// File: rtl/pwm_gate_stage.sv
module pwm_gate_stage #(
  parameter int CW        = 12,
  parameter int BLANK_CYC = 82
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] duty,
  input  logic          ocp,
  input  logic [CW:0]   cnt,
  input  logic [CW:0]   cnt_nx,
  input  logic [CW+1:0] lim,
  output logic          gate
);
  localparam int CNW = CW + 1;
  localparam int LW  = CW + 2;

  logic term, term_nx, gate_nx, start, cut;

  assign start   = (cnt_nx == '0);
  assign cut     = ocp && (cnt >= CNW'(BLANK_CYC));
  assign term_nx = start ? 1'b0 : (term | cut);

  always_comb begin
    if (!en)        gate_nx = 1'b0;
    else if (start) gate_nx = (duty != '0) && (lim != '0);
    else            gate_nx = gate && (cnt_nx < CNW'(duty)) &&
                              (LW'(cnt_nx) < lim) && !term_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term <= 1'b0;
      gate <= 1'b0;
    end else begin
      term <= term_nx;
      gate <= gate_nx;
    end
  end

  // R11: a low enable at one edge means a low gate after it.
  a_r11_enable_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> !gate);

  // R2: the gate only turns on where the sawtooth starts a cycle.
  a_r2_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> (cnt == '0));

  // R5: a current-limit flag past blanking ends the pulse.
  a_r5_ocp_cuts: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && ocp && cnt >= CNW'(BLANK_CYC)) |=> (!gate || cnt == '0));

  // R6: inside the blanking window the pulse carries on.
  a_r6_blank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && gate && cnt < CNW'(BLANK_CYC) && cnt_nx != '0 &&
     cnt_nx < CNW'(duty) && LW'(cnt_nx) < lim) |=> gate);
endmodule

// File: rtl/pwm_sync_gate.sv
module pwm_sync_gate #(
  parameter int CW          = 12,
  parameter int BLANK_CYC   = 82,
  parameter int MIN_OFF     = 16,
  parameter int SYNC_WMIN   = 25,
  parameter int SYNC_WMAX   = 3950,
  parameter int SYNC_IMIN   = 1000,
  parameter int SYNC_MARGIN = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] duty,
  input  logic [CW-1:0] period,
  input  logic          sync_in,
  input  logic          ocp,
  output logic          gate
);
  logic          locked, restart;
  logic [CW:0]   ival, cnt, cnt_nx;
  logic [CW+1:0] lim;

  pwm_sync_qual #(
    .CW(CW), .SYNC_WMIN(SYNC_WMIN), .SYNC_WMAX(SYNC_WMAX),
    .SYNC_IMIN(SYNC_IMIN), .SYNC_MARGIN(SYNC_MARGIN)
  ) u_qual (
    .clk(clk), .rst_n(rst_n), .en(en), .sync_in(sync_in), .period(period),
    .locked(locked), .restart(restart), .ival(ival)
  );

  pwm_ramp #(.CW(CW), .MIN_OFF(MIN_OFF)) u_ramp (
    .clk(clk), .rst_n(rst_n), .en(en), .period(period), .locked(locked),
    .restart(restart), .ival(ival), .cnt(cnt), .cnt_nx(cnt_nx), .lim(lim)
  );

  pwm_gate_stage #(.CW(CW), .BLANK_CYC(BLANK_CYC)) u_gate (
    .clk(clk), .rst_n(rst_n), .en(en), .duty(duty), .ocp(ocp),
    .cnt(cnt), .cnt_nx(cnt_nx), .lim(lim), .gate(gate)
  );

  // R1: the gate stays low while reset is applied.
  always_comb begin
    if (!rst_n) a_r1_reset_low: assert (!gate);
  end
endmodule

// File: tb/pwm_sync_gate_tb_top.sv
module pwm_sync_gate_tb_top;
  localparam int CW = 10, BLANK = 6, MINOFF = 4, WMIN = 3, WMAX = 40;
  localparam int IMIN = 20, MARGIN = 10;
  localparam int CNT_MAX = (1 << (CW + 1)) - 1;
  localparam int ICNT_MAX = (1 << (CW + 2)) - 1;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, sync_in = 1'b0, ocp = 1'b0;
  logic [CW-1:0] duty = '0, period = 10'd99;
  logic gate;

  pwm_sync_gate #(
    .CW(CW), .BLANK_CYC(BLANK), .MIN_OFF(MINOFF), .SYNC_WMIN(WMIN),
    .SYNC_WMAX(WMAX), .SYNC_IMIN(IMIN), .SYNC_MARGIN(MARGIN)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .duty(duty), .period(period),
    .sync_in(sync_in), .ocp(ocp), .gate(gate)
  );

  always #2 clk = ~clk;  // 250 MHz

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string cur_req = "R1";

  // ---------------- behavioural reference model ----------------
  int m1, m2, m3, mw, mi, mprev, mlock, mph, mival, mc, mterm, mg;
  always @(posedge clk) begin
    int rise, fall, wev, fev, tmo, pe, rst_c, cn, lim, tn, gn, lockn, per;
    per = int'(period);
    if (!rst_n) begin
      m1 = 0; m2 = 0; m3 = 0; mw = 0; mi = 0; mprev = 0; mlock = 0;
      mph = 0; mival = 0; mc = CNT_MAX; mterm = 0; mg = 0;
    end else begin
      rise = (m2 && !m3);
      fall = (!m2 && m3);
      wev  = fall && mw >= WMIN && mw <= WMAX;
      fev  = wev && mprev && mi >= IMIN && 2 * mi <= per + 1 + MARGIN;
      tmo  = mlock && mi > per + MARGIN;
      pe   = mlock && mph;
      rst_c = en && fev && !pe;
      lim  = mlock ? 2 * mival - MINOFF : per + 1 - MINOFF;
      if (!en) cn = CNT_MAX;
      else if (rst_c) cn = 0;
      else if (mlock) cn = (mc == CNT_MAX) ? mc : mc + 1;
      else cn = (mc >= per) ? 0 : mc + 1;
      tn = (cn == 0) ? 0 : (mterm || (ocp && mc >= BLANK));
      if (!en) gn = 0;
      else if (cn == 0) gn = (duty != 0) && (lim > 0);
      else gn = mg && cn < int'(duty) && cn < lim && !tn;
      if (!en) lockn = 0;
      else if (fev) lockn = 1;
      else if (wev || tmo) lockn = 0;
      else lockn = mlock;
      if (!lockn) mph = 0; else if (fev) mph = !pe;
      if (fev) mival = mi;
      mlock = lockn;
      if (wev) mi = 1; else if (mi < ICNT_MAX) mi = mi + 1;
      if (wev) mprev = 1;
      if (rise) mw = 1; else if (m2 && mw <= WMAX) mw = mw + 1;
      m3 = m2; m2 = m1; m1 = sync_in;
      mc = cn; mterm = tn; mg = gn;
    end
  end

  // ---------------- compare, monitor, sync source ----------------
  int last_per = 0, last_hi = 0, rise_cyc = 0, hi_total = 0;
  logic gprev = 1'b0;
  always @(negedge clk) begin
    cyc++;
    n_cmp++;
    if (gate !== mg[0]) begin
      n_bad++;
      $display("FAIL %s cycle %0d gate actual %0b expected %0b", cur_req, cyc, gate, mg[0]);
    end
    if (gate && !gprev) begin last_per = cyc - rise_cyc; rise_cyc = cyc; end
    if (!gate && gprev) last_hi = cyc - rise_cyc;
    if (gate) hi_total++;
    gprev = gate;
  end

  int sync_on = 0, sync_w = 5, sync_i = 45, sp = 0;
  always @(negedge clk) begin
    if (sync_on != 0) begin
      sp = (sp + 1 >= sync_i) ? 0 : sp + 1;
      sync_in = (sp < sync_w);
    end else begin
      sp = 0;
      sync_in = 1'b0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rise();
    logic p;
    p = gate;
    forever begin
      @(negedge clk);
      if (gate && !p) break;
      p = gate;
    end
  endtask

  initial begin
    run(5);
    chk("R1 gate in reset", int'(gate), 0);
    @(negedge clk) rst_n = 1'b1;
    run(3);
    chk("R1 gate after reset", int'(gate), 0);

    cur_req = "R2"; en = 1'b1; duty = 10'd30;
    run(400);
    chk("R2 free period", last_per, 100);
    cur_req = "R3";
    chk("R3 high time", last_hi, 30);

    cur_req = "R4"; duty = 10'd200;
    run(300);
    chk("R4 free ceiling", last_hi, 96);

    cur_req = "R3"; duty = 10'd0; run(100);
    hi_total = 0; run(300);
    chk("R3 zero duty", hi_total, 0);

    cur_req = "R6"; duty = 10'd60; run(200);
    wait_rise();
    ocp = 1'b1; run(2); ocp = 1'b0;
    run(150);
    chk("R6 blank window", last_hi, 60);

    cur_req = "R5"; ocp = 1'b1;
    run(300);
    chk("R5 cut width", last_hi, BLANK + 1);
    ocp = 1'b0; run(200);

    cur_req = "R7"; sync_w = 1; sync_i = 45; sync_on = 1;
    run(500);
    chk("R7 narrow ignored", last_per, 100);
    sync_w = 50; sync_i = 100; run(500);
    chk("R7 wide ignored", last_per, 100);

    cur_req = "R8"; sync_w = 5; sync_i = 45;
    run(600);
    chk("R8 locked period", last_per, 90);
    cur_req = "R4"; duty = 10'd200; run(300);
    chk("R4 locked ceiling", last_hi, 86);
    duty = 10'd40;

    cur_req = "R9"; sync_i = 15; run(600);
    chk("R9 too fast", last_per, 100);
    sync_i = 58; run(700);
    chk("R9 too slow", last_per, 100);

    cur_req = "R10"; sync_i = 45; run(500);
    chk("R10 relocked first", last_per, 90);
    sync_on = 0; run(600);
    chk("R10 fallback", last_per, 100);

    cur_req = "R11"; sync_on = 1; run(500);
    wait_rise(); run(3);
    en = 1'b0; run(1);
    chk("R11 gate low after disable", int'(gate), 0);
    run(10); en = 1'b1; run(600);
    chk("R11 relock", last_per, 90);

    sync_on = 0; run(50);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule